// File: doc/BRIEF.md
# 2B1Q Receive Frame Synchronizer

This block sits behind the slicer of a 2B1Q line receiver. It takes one decided quat per symbol strobe and finds frame alignment by watching for a fixed 9-quat syncword. It confirms that the syncword returns every 120 quats before it trusts the alignment. Once locked, it maps each non-sync quat back to a bit pair, undoes the self-synchronizing line scrambler, and emits the payload pairs with frame-start and superframe-start markers.

A syncword that arrives inverted marks the first frame of an 8-frame superframe. The block reports superframe phase only while that inverted word keeps returning on schedule. Equalization, timing recovery, slicing and the meaning of the overhead bits are handled elsewhere.

Top module: `rx_frame_sync`

## Requirements
- R1: During and just after reset, every output is low.
- R2: Quat level codes on `sym_level` are 3 = +3, 2 = +1, 1 = -1 and 0 = -3. They map to (first bit, second bit) pairs 10, 11, 01 and 00. The first bit is the sign bit, sent before the magnitude bit, and appears on `pay_bits[1]`.
- R3: While searching, a strobe whose quat completes the nine most recent quats as +3 +3 -3 -3 -3 +3 -3 +3 +3, or as that word with every quat negated, makes that quat the last sync quat of a frame. This is checked on every strobe, and only after at least nine quats have been received since reset.
- R4: `frame_locked` rises at the strobe that completes the third syncword (normal or inverted) found at 120-quat spacing.
- R5: During confirmation, a missing syncword at the expected position sends the block back to searching.
- R6: While locked, `frame_locked` falls at the strobe ending the fourth syncword position in a row with no syncword. Any syncword found clears the miss run.
- R7: A payload pair is output one clock after its strobe, only while frame lock is held, and only for quats at positions 9..119 of a frame. Sync quats are never output.
- R8: Each bit is descrambled as d = r XOR r(-18) XOR r(-23), where r is the serial received bit stream, sign bit first. The stream holds every received bit except the bits of quats at sync positions while aligned.
- R9: `pay_frame_start` is high with the first payload pair of each frame, at position 9.
- R10: `sf_locked` rises when an inverted syncword is found while frame lock is held, and that frame becomes superframe frame 0. `pay_sf_start` is high with `pay_frame_start` in frame-0 frames while `sf_locked` is high.
- R11: `sf_locked` falls when an inverted syncword appears outside frame 0, when frame 0 lacks an inverted syncword, or when frame lock is lost.
- R12: Clocks without `sym_valid` change no state and produce no payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Symbol strobe |
| sym_level | input | 2 | Decided quat level code |
| pay_valid | output | 1 | Payload pair strobe |
| pay_bits | output | 2 | Descrambled pair; bit 1 is first in time |
| pay_frame_start | output | 1 | First payload pair of a frame |
| pay_sf_start | output | 1 | First payload pair of superframe frame 0 |
| frame_locked | output | 1 | Frame alignment held |
| sf_locked | output | 1 | Superframe phase held |

## Verification
The assertions assume that `sym_valid` is a single-cycle strobe with a legal level code and that reset is held until the first strobe. The bench drives one strobe per clock at most, with randomly placed idle clocks between strobes, so alignment must survive gaps. Frames come from a scrambler in the bench that runs only on payload bits. The bench also adds leading noise, a shift in alignment, corrupted first sync quats and an out-of-place inverted word. Together these reach the lock, miss-recovery, loss and superframe-drop paths.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } align_st_e;

  // Level code to (sign, magnitude) pair.
  function automatic logic [1:0] level_to_pair(input logic [1:0] lvl);
    logic [1:0] p;
    case (lvl)
      2'd3:    p = 2'b10;
      2'd2:    p = 2'b11;
      2'd1:    p = 2'b01;
      default: p = 2'b00;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rfs_sync_detect.sv
module rfs_sync_detect #(
  parameter int SYNC_QUATS = 9,
  parameter logic [2*SYNC_QUATS-1:0] SYNC_WORD = 18'b11_11_00_00_00_11_00_11_11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_level,
  output logic       hit_norm,
  output logic       hit_inv
);
  localparam int HW = 2 * (SYNC_QUATS - 1);
  localparam int FW = $clog2(SYNC_QUATS);
  localparam logic [FW-1:0] FULL = FW'(SYNC_QUATS - 1);

  logic [HW-1:0]           hist_q;
  logic [FW-1:0]           fill_q;
  logic [2*SYNC_QUATS-1:0] window;
  logic                    primed;

  assign window   = {hist_q, sym_level};
  assign primed   = (fill_q == FULL);
  assign hit_norm = sym_valid && primed && (window == SYNC_WORD);
  assign hit_inv  = sym_valid && primed && (window == ~SYNC_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (sym_valid) begin
      hist_q <= window[HW-1:0];
      if (!primed) fill_q <= fill_q + 1'b1;
    end
  end

  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_norm && hit_inv)); // R3

endmodule

// File: rtl/rfs_align_fsm.sv
module rfs_align_fsm
  import rfs_pkg::*;
#(
  parameter int FRAME_QUATS = 120,
  parameter int SYNC_QUATS  = 9,
  parameter int LOCK_HITS   = 3,
  parameter int LOSS_MISSES = 4,
  parameter int SF_FRAMES   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_valid,
  input  logic hit_norm,
  input  logic hit_inv,
  output logic aligned,
  output logic locked,
  output logic sync_slot,
  output logic frame_first,
  output logic sf_locked,
  output logic sf_first,
  output logic [$clog2(FRAME_QUATS)-1:0] pos
);
  localparam int PW = $clog2(FRAME_QUATS);
  localparam int HTW = $clog2(LOCK_HITS + 1);
  localparam int MW = $clog2(LOSS_MISSES + 1);
  localparam int SFW = (SF_FRAMES > 1) ? $clog2(SF_FRAMES) : 1;
  localparam logic [PW-1:0] POS_CHECK = PW'(SYNC_QUATS - 1);
  localparam logic [PW-1:0] POS_FIRST = PW'(SYNC_QUATS);
  localparam logic [PW-1:0] POS_LAST  = PW'(FRAME_QUATS - 1);
  localparam logic [HTW-1:0] HITS_DONE = HTW'(LOCK_HITS - 1);
  localparam logic [MW-1:0]  MISS_DONE = MW'(LOSS_MISSES - 1);
  localparam logic [SFW-1:0] SF_LAST   = SFW'(SF_FRAMES - 1);

  align_st_e      state_q;
  logic [PW-1:0]  pos_q;
  logic [HTW-1:0] hits_q;
  logic [MW-1:0]  miss_q;
  logic           sf_q;
  logic [SFW-1:0] fidx_q;

  // Named events
  logic any_hit, at_check, at_wrap;
  logic ev_found, ev_lock, ev_vmiss, ev_loss, ev_sf_acq, ev_sf_drop;

  assign any_hit   = hit_norm || hit_inv;
  assign aligned   = (state_q != ST_SEARCH);
  assign at_check  = sym_valid && aligned && (pos_q == POS_CHECK);
  assign at_wrap   = sym_valid && aligned && (pos_q == POS_LAST);
  assign ev_found  = sym_valid && (state_q == ST_SEARCH) && any_hit;
  assign ev_lock   = at_check && (state_q == ST_VERIFY) && any_hit && (hits_q == HITS_DONE);
  assign ev_vmiss  = at_check && (state_q == ST_VERIFY) && !any_hit;
  assign ev_loss   = at_check && (state_q == ST_LOCKED) && !any_hit && (miss_q == MISS_DONE);
  assign ev_sf_acq = at_check && (state_q == ST_LOCKED) && !sf_q && hit_inv;
  assign ev_sf_drop = ev_loss ||
    (at_check && (state_q == ST_LOCKED) && sf_q && ((fidx_q == '0) != hit_inv));

  assign locked      = (state_q == ST_LOCKED);
  assign sync_slot   = aligned && (pos_q < POS_FIRST);
  assign frame_first = (pos_q == POS_FIRST);
  assign sf_locked   = sf_q;
  assign sf_first    = (fidx_q == '0);
  assign pos         = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      pos_q   <= '0;
      hits_q  <= '0;
      miss_q  <= '0;
    end else if (sym_valid) begin
      if (ev_found) begin
        state_q <= ST_VERIFY;
        hits_q  <= HTW'(1);
        pos_q   <= POS_FIRST;
      end else if (aligned) begin
        pos_q <= at_wrap ? '0 : pos_q + 1'b1;
        if (ev_lock) begin
          state_q <= ST_LOCKED;
          miss_q  <= '0;
        end else if (ev_vmiss || ev_loss) begin
          state_q <= ST_SEARCH;
        end else if (at_check && state_q == ST_VERIFY) begin
          hits_q <= hits_q + 1'b1;
        end else if (at_check && state_q == ST_LOCKED) begin
          miss_q <= any_hit ? '0 : miss_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_q   <= 1'b0;
      fidx_q <= '0;
    end else begin
      if (ev_sf_drop)     sf_q <= 1'b0;
      else if (ev_sf_acq) sf_q <= 1'b1;
      if (ev_sf_acq)    fidx_q <= '0;
      else if (at_wrap) fidx_q <= (fidx_q == SF_LAST) ? '0 : fidx_q + 1'b1;
    end
  end

  AST_LOCK_FROM_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(state_q == ST_VERIFY && pos_q == POS_CHECK)); // R4
  AST_LOSS_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(pos_q == POS_CHECK && !any_hit)); // R6
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LAST); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(state_q) && $stable(pos_q)); // R12

endmodule

// File: rtl/rfs_descrambler.sv
module rfs_descrambler
  import rfs_pkg::*;
#(
  parameter int TAP_A = 18,
  parameter int TAP_B = 23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_level,
  input  logic       feed,
  input  logic       emit,
  input  logic       frame_first,
  input  logic       sf_first,
  output logic       pay_valid,
  output logic [1:0] pay_bits,
  output logic       pay_frame_start,
  output logic       pay_sf_start
);
  logic [TAP_B-1:0] hist_q;
  logic [1:0]       rx_pair;
  logic [1:0]       clear_pair;
  logic             take, show;

  // Two serial steps of d = r ^ r(-A) ^ r(-B); hist[0] is the newest bit.
  function automatic logic [1:0] descramble2(input logic [1:0] r, input logic [TAP_B-1:0] h);
    logic [TAP_B-1:0] h1;
    logic first, second;
    first  = r[1] ^ h[TAP_A-1] ^ h[TAP_B-1];
    h1     = {h[TAP_B-2:0], r[1]};
    second = r[0] ^ h1[TAP_A-1] ^ h1[TAP_B-1];
    return {first, second};
  endfunction

  assign rx_pair    = level_to_pair(sym_level);
  assign clear_pair = descramble2(rx_pair, hist_q);
  assign take       = sym_valid && feed;
  assign show       = take && emit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q          <= '0;
      pay_valid       <= 1'b0;
      pay_bits        <= '0;
      pay_frame_start <= 1'b0;
      pay_sf_start    <= 1'b0;
    end else begin
      if (take) hist_q <= {hist_q[TAP_B-3:0], rx_pair};
      pay_valid       <= show;
      pay_bits        <= show ? clear_pair : 2'b00;
      pay_frame_start <= show && frame_first;
      pay_sf_start    <= show && frame_first && sf_first;
    end
  end

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pay_frame_start |-> pay_valid); // R9

endmodule

// File: rtl/rx_frame_sync.sv
module rx_frame_sync #(
  parameter int FRAME_QUATS = 120,
  parameter int SYNC_QUATS  = 9,
  parameter logic [2*SYNC_QUATS-1:0] SYNC_WORD = 18'b11_11_00_00_00_11_00_11_11,
  parameter int LOCK_HITS   = 3,
  parameter int LOSS_MISSES = 4,
  parameter int SF_FRAMES   = 8,
  parameter int TAP_A       = 18,
  parameter int TAP_B       = 23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_level,
  output logic       pay_valid,
  output logic [1:0] pay_bits,
  output logic       pay_frame_start,
  output logic       pay_sf_start,
  output logic       frame_locked,
  output logic       sf_locked
);
  localparam int PW = $clog2(FRAME_QUATS);

  logic hit_norm, hit_inv;
  logic aligned, locked, sync_slot, frame_first, sf_lk, sf_first;
  logic [PW-1:0] pos;

  rfs_sync_detect #(.SYNC_QUATS(SYNC_QUATS), .SYNC_WORD(SYNC_WORD)) u_det (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_level(sym_level),
    .hit_norm(hit_norm), .hit_inv(hit_inv));

  rfs_align_fsm #(
    .FRAME_QUATS(FRAME_QUATS), .SYNC_QUATS(SYNC_QUATS), .LOCK_HITS(LOCK_HITS),
    .LOSS_MISSES(LOSS_MISSES), .SF_FRAMES(SF_FRAMES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
    .hit_norm(hit_norm), .hit_inv(hit_inv),
    .aligned(aligned), .locked(locked), .sync_slot(sync_slot),
    .frame_first(frame_first), .sf_locked(sf_lk), .sf_first(sf_first), .pos(pos));

  rfs_descrambler #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_dsc (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_level(sym_level),
    .feed(!sync_slot), .emit(locked), .frame_first(frame_first),
    .sf_first(sf_first && sf_lk),
    .pay_valid(pay_valid), .pay_bits(pay_bits),
    .pay_frame_start(pay_frame_start), .pay_sf_start(pay_sf_start));

  assign frame_locked = locked;
  assign sf_locked    = sf_lk;

  AST_PAY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> frame_locked); // R7
  AST_NO_SYNC_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> $past(pos) >= PW'(SYNC_QUATS)); // R7
  AST_SF_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sf_locked |-> frame_locked); // R11
  AST_SF_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    pay_sf_start |-> pay_frame_start); // R10

endmodule

// File: tb/rx_frame_sync_test.sv
module rx_frame_sync_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       sym_valid;
  logic [1:0] sym_level;
  logic       pay_valid, pay_frame_start, pay_sf_start, frame_locked, sf_locked;
  logic [1:0] pay_bits;

  rx_frame_sync uut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_level(sym_level),
    .pay_valid(pay_valid), .pay_bits(pay_bits), .pay_frame_start(pay_frame_start),
    .pay_sf_start(pay_sf_start), .frame_locked(frame_locked), .sf_locked(sf_locked));

  int total = 0;
  int bad = 0;
  bit done = 0;
  int sw [9] = '{3, 3, 0, 0, 0, 3, 0, 3, 3};

  // Reference model state
  int m_st, m_pos, m_hits, m_miss, m_sfl, m_fidx;
  int m_win[$];
  bit m_dh[$];
  bit e_valid, e_fs, e_sfs, e_locked, e_sfl;
  bit [1:0] e_bits;
  bit tx_sc[$];

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic model_step(input int lv);
    bit hn, hi, sgn, mag, o1, o2, slot, hit;
    m_win.push_back(lv);
    if (m_win.size() > 9) void'(m_win.pop_front());
    hn = 0; hi = 0;
    if (m_win.size() == 9) begin
      hn = 1; hi = 1;
      for (int i = 0; i < 9; i++) begin
        if (m_win[i] != sw[i]) hn = 0;
        if (m_win[i] != 3 - sw[i]) hi = 0;
      end
    end
    sgn = (lv >= 2);
    mag = (lv == 1) || (lv == 2);
    slot = (m_st != 0) && (m_pos < 9);
    if (!slot) begin
      o1 = sgn ^ m_dh[17] ^ m_dh[22];
      m_dh.push_front(sgn); void'(m_dh.pop_back());
      o2 = mag ^ m_dh[17] ^ m_dh[22];
      m_dh.push_front(mag); void'(m_dh.pop_back());
      if (m_st == 2) begin
        e_valid = 1; e_bits = {o1, o2};
        e_fs = (m_pos == 9);
        e_sfs = (m_pos == 9) && m_sfl && (m_fidx == 0);
      end
    end
    hit = hn || hi;
    if (m_st == 0) begin
      if (hit) begin m_st = 1; m_hits = 1; m_pos = 9; end
    end else begin
      if (m_pos == 8) begin
        if (m_st == 1) begin
          if (!hit) m_st = 0;
          else if (m_hits == 2) begin m_st = 2; m_miss = 0; end
          else m_hits++;
        end else begin
          if (m_sfl) begin
            if ((m_fidx == 0) != hi) m_sfl = 0;
          end else if (hi) begin
            m_sfl = 1; m_fidx = 0;
          end
          if (hit) m_miss = 0;
          else if (m_miss == 3) begin m_st = 0; m_sfl = 0; end
          else m_miss++;
        end
      end
      if (m_pos == 119) begin m_pos = 0; m_fidx = (m_fidx + 1) % 8; end
      else m_pos++;
    end
  endtask

  always @(posedge clk) begin
    e_valid = 0; e_bits = 0; e_fs = 0; e_sfs = 0;
    if (!rst_n) begin
      m_st = 0; m_pos = 0; m_hits = 0; m_miss = 0; m_sfl = 0; m_fidx = 0;
      m_win.delete(); m_dh.delete();
      for (int i = 0; i < 23; i++) m_dh.push_back(0);
    end else if (sym_valid) begin
      model_step(int'(sym_level));
    end
    e_locked = (m_st == 2);
    e_sfl = m_sfl;
  end

  task automatic compare();
    check(pay_valid == e_valid, "R7 pay_valid", pay_valid, e_valid);
    check(pay_bits == e_bits, "R2 R8 pay_bits", pay_bits, e_bits);
    check(pay_frame_start == e_fs, "R9 pay_frame_start", pay_frame_start, e_fs);
    check(pay_sf_start == e_sfs, "R10 pay_sf_start", pay_sf_start, e_sfs);
    check(frame_locked == e_locked, "R4 R5 R6 frame_locked", frame_locked, e_locked);
    check(sf_locked == e_sfl, "R11 sf_locked", sf_locked, e_sfl);
  endtask

  task automatic tick(input bit v, input int lv);
    @(negedge clk);
    if (rst_n) compare();
    sym_valid = v;
    sym_level = 2'(lv);
  endtask

  task automatic send_q(input int lv);
    if ($urandom % 4 == 0) tick(0, $urandom % 4);
    tick(1, lv);
  endtask

  // kind: 0 normal sync, 1 inverted sync, 2 corrupted sync
  task automatic send_frame(input int kind);
    bit d, s1, s0;
    for (int i = 0; i < 9; i++) begin
      if (kind == 2 && i == 0) send_q(1);
      else send_q(kind == 1 ? 3 - sw[i] : sw[i]);
    end
    for (int i = 0; i < 111; i++) begin
      d = bit'($urandom % 2);
      s1 = d ^ tx_sc[17] ^ tx_sc[22];
      tx_sc.push_front(s1); void'(tx_sc.pop_back());
      d = bit'($urandom % 2);
      s0 = d ^ tx_sc[17] ^ tx_sc[22];
      tx_sc.push_front(s0); void'(tx_sc.pop_back());
      send_q(s1 ? (s0 ? 2 : 3) : (s0 ? 1 : 0));
    end
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) send_q($urandom % 4);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 23; i++) tx_sc.push_back(0);
    rst_n = 0; sym_valid = 0; sym_level = 0;
    repeat (4) @(negedge clk);
    check({pay_valid, pay_bits, pay_frame_start, pay_sf_start, frame_locked, sf_locked} == 0,
          "R1 outputs in reset", int'(pay_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check({pay_valid, frame_locked, sf_locked} == 0, "R1 outputs after reset", int'(frame_locked), 0);

    noise(30);
    for (int k = 0; k < 20; k++) begin
      send_frame((k % 8 == 2) ? 1 : 0);
      if (k == 1) check(frame_locked == 0, "R4 not locked after two syncwords", frame_locked, 0);
      if (k == 2) check(frame_locked == 1, "R4 locked after third syncword", frame_locked, 1);
      if (k == 9) check(sf_locked == 0, "R10 no superframe before inverted word", sf_locked, 0);
      if (k == 10) check(sf_locked == 1, "R10 superframe acquired", sf_locked, 1);
      if (k == 18) check(sf_locked == 1, "R10 inverted word returned after 8 frames", sf_locked, 1);
    end
    send_frame(1);
    check(sf_locked == 0, "R11 misplaced inverted word drops superframe", sf_locked, 0);
    check(frame_locked == 1, "R11 frame lock kept", frame_locked, 1);
    for (int k = 0; k < 3; k++) send_frame(2);
    send_frame(0);
    check(frame_locked == 1, "R6 three misses then hit keep lock", frame_locked, 1);
    for (int k = 0; k < 5; k++) tick(0, k % 4);
    @(negedge clk);
    compare();
    check(pay_valid == 0, "R12 no payload on idle clocks", pay_valid, 0);
    check(frame_locked == 1, "R12 idle clocks keep lock", frame_locked, 1);
    sym_valid = 0;
    for (int k = 0; k < 4; k++) send_frame(2);
    check(frame_locked == 0, "R6 four misses lose lock", frame_locked, 0);
    noise(41);
    send_frame(0); send_frame(0); send_frame(2);
    check(frame_locked == 0, "R5 miss during confirmation", frame_locked, 0);
    send_frame(0); send_frame(0); send_frame(0);
    check(frame_locked == 1, "R3 reacquired at new offset", frame_locked, 1);
    noise(20);
    tick(0, 0);
    tick(0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule